// File: doc/BRIEF.md
# Input Magnitude Threshold Detector

This block watches a stream of signed I and Q samples and flags, one sample at a time, whether the sample's magnitude sits above or below a programmable level. It does not compute an exact square root. It forms a shift-and-add estimate, max(|I|,|Q|) + 3/8·min(|I|,|Q|), and compares that estimate with an 8-bit unsigned threshold. The threshold has one integer bit and seven fraction bits. A real-input mode ignores the Q sample, so the estimate becomes |I|.

The result is a single registered flag. A polarity input selects its meaning: "estimate above threshold" or "estimate below threshold". The flag changes only when a valid sample arrives, and it holds its value between samples. Typical uses are driving a level indicator or feeding an external gain controller.

Top module: `mag_thresh_detect`

## Requirements
- R1: While reset is asserted and after its release, `levelFlag` reads 0 until the first valid sample has been evaluated.
- R2: The threshold code T has value T/128: bit 7 weighs 1 and bit 0 weighs 1/128, so codes 0x00..0xFF cover 0 to 1.9921875. A sample code S is a two's complement fraction of value S/512.
- R3: In complex mode (`realMode`=0) the estimate equals max(|I|,|Q|) + 3/8·min(|I|,|Q|) exactly, with no rounding of the 3/8 term.
- R4: In real mode (`realMode`=1) the Q sample has no effect, and the estimate equals |I|.
- R5: The magnitude of the most negative sample code (0x200) is taken as 511, not 512.
- R6: With `aboveSense`=1, the flag is 1 exactly when the estimate is strictly greater than the threshold.
- R7: With `aboveSense`=0, the flag is 1 exactly when the estimate is strictly less than the threshold. An estimate equal to the threshold gives 0 under either polarity.
- R8: A sample presented with `sampleValid`=1 at a rising clock edge sets `levelFlag` after that edge. Without `sampleValid`, `levelFlag` holds its value, whatever the other inputs do.
- R9: The estimate never exceeds 1.375, so with `aboveSense`=1 any threshold code of 0xB0 or higher never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe; qualifies the I, Q, mode, threshold and polarity inputs |
| sampleI | input | 10 | In-phase sample, two's complement |
| sampleQ | input | 10 | Quadrature sample, two's complement; ignored in real mode |
| realMode | input | 1 | 1 = real input (Q ignored), 0 = complex input |
| threshold | input | 8 | Unsigned threshold, one integer bit and seven fraction bits |
| aboveSense | input | 1 | 1 = flag means above threshold, 0 = flag means below |
| levelFlag | output | 1 | Registered comparison result |

## Verification
The only result is `levelFlag`. It is due one cycle after the rising edge that samples `sampleValid`, because the comparison passes through exactly one register. The bench drives each sample on a falling edge and drops the strobe on the next falling edge. It compares the flag at that second falling edge against a value computed from the requirements. Idle cycles then scramble every data input with the strobe low and check, at the next falling edge, that the flag still holds the last expected value.

// File: rtl/mag_thresh_pkg.sv
package mag_thresh_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic loadFlag;    // capture a new comparison result this cycle
    logic realMode;    // suppress the Q lane
    logic aboveSense;  // polarity of the flag
  } lvlStrobes_t;

  // Coefficient of the minor axis term, expressed in eighths
  localparam int unsigned MINOR_EIGHTHS = 3;

endpackage

// File: rtl/lvl_abs_sat.sv
module lvl_abs_sat #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-2:0] mag
);
  logic isMostNeg;
  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    isMostNeg = din[SAMPLE_W-1] & ~(|din[SAMPLE_W-2:0]);
    negated   = (~din) + {{(SAMPLE_W-1){1'b0}}, 1'b1};
    if (isMostNeg)
      mag = '1;
    else if (din[SAMPLE_W-1])
      mag = negated[SAMPLE_W-2:0];
    else
      mag = din[SAMPLE_W-2:0];
  end
endmodule

// File: rtl/lvl_ctrl.sv
module lvl_ctrl
  import mag_thresh_pkg::*;
(
  input  logic        sampleValid,
  input  logic        realMode,
  input  logic        aboveSense,
  output lvlStrobes_t strobes
);
  always_comb begin
    strobes.loadFlag   = sampleValid;
    strobes.realMode   = realMode;
    strobes.aboveSense = aboveSense;
  end
endmodule

// File: rtl/lvl_datapath.sv
module lvl_datapath
  import mag_thresh_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned THRESH_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  lvlStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  input  logic [THRESH_W-1:0] threshold,
  output logic                levelFlag
);
  localparam int unsigned MAG_W   = SAMPLE_W - 1;
  localparam int unsigned EST_W   = MAG_W + 4;
  localparam int unsigned CMP_W   = EST_W + THRESH_W - 1;
  localparam int unsigned N_LANES = 2;

  logic [SAMPLE_W-1:0] laneIn  [N_LANES];
  logic [MAG_W-1:0]    laneMag [N_LANES];

  always_comb begin
    laneIn[0] = sampleI;
    laneIn[1] = strobes.realMode ? '0 : sampleQ;
  end

  for (genvar lane = 0; lane < N_LANES; lane++) begin : g_lane
    lvl_abs_sat #(.SAMPLE_W(SAMPLE_W)) absInst (
      .din (laneIn[lane]),
      .mag (laneMag[lane])
    );
  end

  logic [MAG_W-1:0] majorMag, minorMag;
  logic [EST_W-1:0] estEighths;
  logic [CMP_W-1:0] estAligned, thrAligned;
  logic             isAbove, isBelow, nextFlag;

  always_comb begin
    if (laneMag[0] >= laneMag[1]) begin
      majorMag = laneMag[0];
      minorMag = laneMag[1];
    end else begin
      majorMag = laneMag[1];
      minorMag = laneMag[0];
    end
    // estimate scaled by 8: 8*major + 3*minor
    estEighths = ({{(EST_W-MAG_W){1'b0}}, majorMag} << 3)
               + EST_W'(MINOR_EIGHTHS) * {{(EST_W-MAG_W){1'b0}}, minorMag};
    // bring estimate and threshold onto a common grid
    estAligned = {{(CMP_W-EST_W){1'b0}}, estEighths} << (THRESH_W - 1);
    thrAligned = {{(CMP_W-THRESH_W){1'b0}}, threshold} << (MAG_W + 3);
    isAbove    = estAligned > thrAligned;
    isBelow    = estAligned < thrAligned;
    nextFlag   = strobes.aboveSense ? isAbove : isBelow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      levelFlag <= 1'b0;
    else if (strobes.loadFlag)
      levelFlag <= nextFlag;
  end
endmodule

// File: rtl/mag_thresh_detect.sv
module mag_thresh_detect
  import mag_thresh_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned THRESH_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  input  logic                realMode,
  input  logic [THRESH_W-1:0] threshold,
  input  logic                aboveSense,
  output logic                levelFlag
);
  lvlStrobes_t strobes;

  lvl_ctrl ctrlInst (
    .sampleValid (sampleValid),
    .realMode    (realMode),
    .aboveSense  (aboveSense),
    .strobes     (strobes)
  );

  lvl_datapath #(.SAMPLE_W(SAMPLE_W), .THRESH_W(THRESH_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleI   (sampleI),
    .sampleQ   (sampleQ),
    .threshold (threshold),
    .levelFlag (levelFlag)
  );
endmodule

// File: rtl/mag_thresh_detect_chk.sv
module mag_thresh_detect_chk #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned THRESH_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleI,
  input logic                realMode,
  input logic [THRESH_W-1:0] threshold,
  input logic                aboveSense,
  input logic                levelFlag
);
  // 1.375 expressed as a threshold code
  localparam logic [THRESH_W-1:0] CAP_CODE = THRESH_W'(11 << (THRESH_W - 4));

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !levelFlag);  // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(levelFlag));  // R8

  AST_CAP_NEVER_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && aboveSense && threshold >= CAP_CODE) |=> !levelFlag);  // R9

  AST_REAL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && realMode && aboveSense && sampleI == '0) |=> !levelFlag);  // R4

  AST_NOTHING_BELOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !aboveSense && threshold == '0) |=> !levelFlag);  // R7
endmodule

bind mag_thresh_detect mag_thresh_detect_chk #(
  .SAMPLE_W (SAMPLE_W),
  .THRESH_W (THRESH_W)
) chkInst (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .sampleI     (sampleI),
  .realMode    (realMode),
  .threshold   (threshold),
  .aboveSense  (aboveSense),
  .levelFlag   (levelFlag)
);

// File: tb/mag_thresh_detect_test.sv
`timescale 1ns/1ps
module mag_thresh_detect_test;
  localparam int SAMPLE_W = 10;
  localparam int THRESH_W = 8;
  localparam int FULL     = 1 << (SAMPLE_W - 1);  // 512

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sampleI = '0;
  logic [SAMPLE_W-1:0] sampleQ = '0;
  logic                realMode = 1'b0;
  logic [THRESH_W-1:0] threshold = '0;
  logic                aboveSense = 1'b0;
  logic                levelFlag;

  int checks = 0;
  int failures = 0;
  logic lastExp = 1'b0;

  always #2.5 clk = ~clk;

  mag_thresh_detect #(.SAMPLE_W(SAMPLE_W), .THRESH_W(THRESH_W)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleI(sampleI),
    .sampleQ(sampleQ), .realMode(realMode), .threshold(threshold),
    .aboveSense(aboveSense), .levelFlag(levelFlag)
  );

  function automatic int magOf(input int v);
    if (v == -FULL) return FULL - 1;
    return (v < 0) ? -v : v;
  endfunction

  // estimate*8 compared with threshold on the grid 1/(8*512); threshold code/128
  function automatic logic expFlag(input int iv, input int qv, input logic rm,
                                   input int thr, input logic pol);
    int a, b, mx, mn, est8, lhs, rhs;
    a = magOf(iv);
    b = rm ? 0 : magOf(qv);
    mx = (a > b) ? a : b;
    mn = (a > b) ? b : a;
    est8 = 8 * mx + 3 * mn;
    lhs = est8 * 128;
    rhs = thr * 8 * FULL;
    return pol ? (lhs > rhs) : (lhs < rhs);
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic doSample(input int iv, input int qv, input logic rm,
                          input int thr, input logic pol, input string req);
    @(negedge clk);
    sampleI = SAMPLE_W'(iv); sampleQ = SAMPLE_W'(qv); realMode = rm;
    threshold = THRESH_W'(thr); aboveSense = pol; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    lastExp = expFlag(iv, qv, rm, thr, pol);
    check(levelFlag, lastExp, req);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    sampleI = SAMPLE_W'($urandom); sampleQ = SAMPLE_W'($urandom);
    realMode = 1'($urandom); threshold = THRESH_W'($urandom);
    aboveSense = 1'($urandom); sampleValid = 1'b0;
    @(negedge clk);
    check(levelFlag, lastExp, "R8 hold");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    check(levelFlag, 1'b0, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(levelFlag, 1'b0, "R1 after release");

    // R3: I=Q=256 -> 0.6875 = code 88
    doSample(256, 256, 1'b0, 88, 1'b1, "R3 R6 equal not above");
    doSample(256, 256, 1'b0, 87, 1'b1, "R3 R6 just above");
    doSample(256, -256, 1'b0, 89, 1'b0, "R3 R7 just below");
    doSample(-256, 256, 1'b0, 88, 1'b0, "R7 equal not below");
    // R3: I=100,Q=-40 -> (800+120)/4096 ; thr 29 -> 928/4096
    doSample(100, -40, 1'b0, 29, 1'b0, "R3 minor term");
    doSample(-40, 100, 1'b0, 28, 1'b1, "R3 swapped axes");
    // R2: 0.5 vs codes 0x40 and 0x3F
    doSample(256, 0, 1'b1, 8'h40, 1'b1, "R2 half equal");
    doSample(256, 0, 1'b1, 8'h3F, 1'b1, "R2 half above");
    idleCheck();
    // R5: most negative code
    doSample(-512, 0, 1'b1, 128, 1'b0, "R5 below one");
    doSample(-512, 0, 1'b1, 127, 1'b1, "R5 above 127/128");
    // R9: full scale both lanes
    doSample(-512, -512, 1'b0, 8'hAF, 1'b1, "R9 below cap crossed");
    doSample(-512, -512, 1'b0, 8'hB0, 1'b1, "R9 cap never crossed");
    doSample(511, 511, 1'b0, 8'hFF, 1'b1, "R9 max threshold");
    idleCheck();
    // R4: Q ignored in real mode
    doSample(0, 511, 1'b1, 1, 1'b1, "R4 real ignores Q");
    doSample(0, 511, 1'b0, 1, 1'b1, "R4 complex uses Q");
    doSample(200, -512, 1'b1, 50, 1'b1, "R4 real uses I only");
    idleCheck();

    for (int n = 0; n < 400; n++) begin
      int iv, qv, thr;
      logic rm, pol;
      iv  = int'($urandom_range(0, 2 * FULL - 1)) - FULL;
      qv  = int'($urandom_range(0, 2 * FULL - 1)) - FULL;
      thr = int'($urandom_range(0, 255));
      rm  = 1'($urandom);
      pol = 1'($urandom);
      doSample(iv, qv, rm, thr, pol, pol ? "R6 random" : "R7 random");
      if (n % 8 == 0) idleCheck();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule